// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs the state changes a processor core makes when it takes an interrupt from an external vectored interrupt controller. The controller supplies four values: the handler address, the register bank the handler runs in, the interrupt level and a non-maskable flag. The core supplies the live status word and the return PC. The block accepts one request per cycle through a valid/ready handshake.

One clock edge after a request is accepted, the block presents the rewritten status word and the next PC. In the same cycle it presents the write strobes that save the old context. The old status goes either to a single exception-save register or to the status slot of the target bank. The return address goes to the target bank's return-address slot. The register banks themselves live outside the block.

Status word layout, used throughout:

| Field | Bits |
|---|---|
| PrevIe | 0 |
| User | 1 |
| ExcBusy | 2 |
| IrqBusy | 3 |
| Level | 9:4 |
| CurBank | 15:10 |
| PrevBank | 21:16 |
| Nmi | 22 |
| BankIrqEn | 23 |
| BankSwitched | 31 |

Top module: `vic_entry`

## Requirements
- R1: While `rstN` is low, `reqReady` and every write strobe (`statusWe`, `xsWe`, `bankStWe`, `bankRaWe`) are 0. `reqReady` is 1 from the first clock edge after reset is released.
- R2: One edge after a request is accepted, `statusWe` is 1 and `newStatus` holds the old status with these changes: CurBank (15:10) is set to the requested bank, Level (9:4) to the requested level and Nmi (22) to the requested flag. BankIrqEn (23) and User (1) are cleared, and IrqBusy (3) is set. All other bits are kept.
- R3: In the same cycle, `newPc` equals the requested handler address.
- R4: If ExcBusy (bit 2) of the old status is 0, PrevBank (21:16) takes the old CurBank. If ExcBusy is 1, PrevBank is kept unchanged.
- R5: If ExcBusy is 0 and the requested bank is 0, `xsWe` is 1 with `xsData` equal to the old status, and `bankStWe` is 0.
- R6: If ExcBusy is 0 and the requested bank is nonzero, `bankStWe` is 1 and `xsWe` is 0. The write targets bank `reqBank` at slot index `ST_SLOT` (default 30). The data is the old status, with BankSwitched (bit 31) ORed in only when the requested bank differs from the old CurBank.
- R7: If ExcBusy is 0, `bankRaWe` is 1, targeting bank `reqBank` at slot index `RA_SLOT` (default 29), with data equal to the request-time `curPc`. This holds for bank 0 and for nonzero banks alike.
- R8: If ExcBusy is 1, the status update still happens, but none of the three save strobes fires.
- R9: A cycle with no accepted request leaves every strobe at 0 on the next edge, and `newPc` does not change. Requests accepted on back-to-back cycles each produce their own one-cycle update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Interrupt request present |
| reqReady | output | 1 | Block can accept a request |
| reqHandler | input | ADDR_W | Handler address |
| reqBank | input | BANK_W | Requested register bank |
| reqLevel | input | 6 | Requested interrupt level |
| reqNmi | input | 1 | Requested non-maskable flag |
| curStatus | input | 32 | Live status word |
| curPc | input | ADDR_W | Return address to save |
| statusWe | output | 1 | Status update strobe |
| newStatus | output | 32 | Rewritten status word |
| newPc | output | ADDR_W | Next PC |
| xsWe | output | 1 | Exception-save register write strobe |
| xsData | output | 32 | Exception-save write data |
| bankStWe | output | 1 | Bank status-slot write strobe |
| bankStSel | output | BANK_W | Bank index for the status-slot write |
| bankStIdx | output | SLOT_W | Slot index for the status-slot write |
| bankStData | output | 32 | Status-slot write data |
| bankRaWe | output | 1 | Bank return-address write strobe |
| bankRaSel | output | BANK_W | Bank index for the return-address write |
| bankRaIdx | output | SLOT_W | Slot index for the return-address write |
| bankRaData | output | ADDR_W | Return-address write data |

## Verification
The status rewrite and the context saves fall in the same cycle, and so do two saves: the bank status slot and the bank return address. The bench provokes this by accepting requests with ExcBusy clear, for bank 0 and for nonzero banks, with and without a change of bank. It judges every strobe and data word at one sampling point, one edge after acceptance. Requests on back-to-back cycles check that an update from the first request neither lingers into the second nor merges with it.

// File: rtl/vic_entry_pkg.sv
package vic_entry_pkg;
  localparam int STAT_W     = 32;
  localparam int ST_PIE     = 0;
  localparam int ST_USER    = 1;
  localparam int ST_XBUSY   = 2;
  localparam int ST_IBUSY   = 3;
  localparam int ST_LVL_LO  = 4;
  localparam int LVL_W      = 6;
  localparam int ST_CUR_LO  = 10;
  localparam int BANKF_W    = 6;
  localparam int ST_PREV_LO = 16;
  localparam int ST_NMI     = 22;
  localparam int ST_BIE     = 23;
  localparam int ST_SWITCH  = 31;

  typedef struct packed {
    logic fire;       // request accepted this cycle
    logic keepPrev;   // record old bank into PrevBank
    logic saveXs;     // old status to exception-save register
    logic saveBank;   // old status to bank status slot
    logic markSwitch; // bank differs from old one
    logic saveRa;     // return address to bank slot
  } entryCtl_t;
endpackage

// File: rtl/vic_entry_ctrl.sv
module vic_entry_ctrl
  import vic_entry_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [STAT_W-1:0]   curStatus,
  output logic                reqReady,
  output entryCtl_t           ctl
);
  logic readyQ;
  logic excFree;
  logic bankNonZero;
  logic [BANKF_W-1:0] oldBank;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady    = readyQ;
  assign oldBank     = curStatus[ST_CUR_LO +: BANKF_W];
  assign excFree     = !curStatus[ST_XBUSY];
  assign bankNonZero = |reqBank;

  always_comb begin
    ctl            = '0;
    ctl.fire       = reqValid && readyQ;
    ctl.keepPrev   = excFree;
    ctl.saveXs     = ctl.fire && excFree && !bankNonZero;
    ctl.saveBank   = ctl.fire && excFree && bankNonZero;
    ctl.markSwitch = BANKF_W'(reqBank) != oldBank;
    ctl.saveRa     = ctl.fire && excFree;
  end

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> reqReady);
endmodule

// File: rtl/vic_entry_dp.sv
module vic_entry_dp
  import vic_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int SLOT_W  = 5,
  parameter int ST_SLOT = 30,
  parameter int RA_SLOT = 29
) (
  input  logic                clk,
  input  logic                rstN,
  input  entryCtl_t           ctl,
  input  logic [ADDR_W-1:0]   reqHandler,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [LVL_W-1:0]    reqLevel,
  input  logic                reqNmi,
  input  logic [STAT_W-1:0]   curStatus,
  input  logic [ADDR_W-1:0]   curPc,
  output logic                statusWe,
  output logic [STAT_W-1:0]   newStatus,
  output logic [ADDR_W-1:0]   newPc,
  output logic                xsWe,
  output logic [STAT_W-1:0]   xsData,
  output logic                bankStWe,
  output logic [BANK_W-1:0]   bankStSel,
  output logic [SLOT_W-1:0]   bankStIdx,
  output logic [STAT_W-1:0]   bankStData,
  output logic                bankRaWe,
  output logic [BANK_W-1:0]   bankRaSel,
  output logic [SLOT_W-1:0]   bankRaIdx,
  output logic [ADDR_W-1:0]   bankRaData
);
  logic [STAT_W-1:0] nextStatus;
  logic [STAT_W-1:0] savedStatus;
  logic [BANK_W-1:0] bankQ;

  always_comb begin
    nextStatus = curStatus;
    nextStatus[ST_CUR_LO +: BANKF_W] = BANKF_W'(reqBank);
    nextStatus[ST_LVL_LO +: LVL_W]   = reqLevel;
    nextStatus[ST_NMI]   = reqNmi;
    nextStatus[ST_BIE]   = 1'b0;
    nextStatus[ST_USER]  = 1'b0;
    nextStatus[ST_IBUSY] = 1'b1;
    if (ctl.keepPrev)
      nextStatus[ST_PREV_LO +: BANKF_W] = curStatus[ST_CUR_LO +: BANKF_W];
  end

  always_comb begin
    savedStatus = curStatus;
    if (ctl.markSwitch) savedStatus[ST_SWITCH] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWe   <= 1'b0;
      xsWe       <= 1'b0;
      bankStWe   <= 1'b0;
      bankRaWe   <= 1'b0;
      newStatus  <= '0;
      newPc      <= '0;
      xsData     <= '0;
      bankStData <= '0;
      bankRaData <= '0;
      bankQ      <= '0;
    end else begin
      statusWe <= ctl.fire;
      xsWe     <= ctl.saveXs;
      bankStWe <= ctl.saveBank;
      bankRaWe <= ctl.saveRa;
      if (ctl.fire) begin
        newStatus  <= nextStatus;
        newPc      <= reqHandler;
        xsData     <= curStatus;
        bankStData <= savedStatus;
        bankRaData <= curPc;
        bankQ      <= reqBank;
      end
    end
  end

  assign bankStSel = bankQ;
  assign bankRaSel = bankQ;
  assign bankStIdx = SLOT_W'(ST_SLOT);
  assign bankRaIdx = SLOT_W'(RA_SLOT);

  assert_update_follows_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> statusWe);
  assert_no_spurious_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> !statusWe && !xsWe && !bankStWe && !bankRaWe);
  assert_pc_is_handler_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> newPc == $past(reqHandler));
  assert_irq_busy_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> newStatus[ST_IBUSY] && !newStatus[ST_USER] && !newStatus[ST_BIE]);
  assert_xs_only_bank0_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> xsWe |-> $past(reqBank) == '0);
  assert_bank_save_has_ra_R7: assert property (@(posedge clk) disable iff (!rstN)
    bankStWe |-> bankRaWe && statusWe);
  assert_busy_no_save_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWe && newStatus[ST_XBUSY] |-> !xsWe && !bankStWe && !bankRaWe);
endmodule

// File: rtl/vic_entry.sv
module vic_entry
  import vic_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int SLOT_W  = 5,
  parameter int ST_SLOT = 30,
  parameter int RA_SLOT = 29
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqHandler,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [5:0]          reqLevel,
  input  logic                reqNmi,
  input  logic [31:0]         curStatus,
  input  logic [ADDR_W-1:0]   curPc,
  output logic                statusWe,
  output logic [31:0]         newStatus,
  output logic [ADDR_W-1:0]   newPc,
  output logic                xsWe,
  output logic [31:0]         xsData,
  output logic                bankStWe,
  output logic [BANK_W-1:0]   bankStSel,
  output logic [SLOT_W-1:0]   bankStIdx,
  output logic [31:0]         bankStData,
  output logic                bankRaWe,
  output logic [BANK_W-1:0]   bankRaSel,
  output logic [SLOT_W-1:0]   bankRaIdx,
  output logic [ADDR_W-1:0]   bankRaData
);
  entryCtl_t ctl;

  vic_entry_ctrl #(.BANK_W(BANK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .curStatus(curStatus), .reqReady(reqReady), .ctl(ctl)
  );

  vic_entry_dp #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W),
    .ST_SLOT(ST_SLOT), .RA_SLOT(RA_SLOT)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqHandler(reqHandler), .reqBank(reqBank), .reqLevel(reqLevel),
    .reqNmi(reqNmi), .curStatus(curStatus), .curPc(curPc),
    .statusWe(statusWe), .newStatus(newStatus), .newPc(newPc),
    .xsWe(xsWe), .xsData(xsData),
    .bankStWe(bankStWe), .bankStSel(bankStSel), .bankStIdx(bankStIdx),
    .bankStData(bankStData),
    .bankRaWe(bankRaWe), .bankRaSel(bankRaSel), .bankRaIdx(bankRaIdx),
    .bankRaData(bankRaData)
  );
endmodule

// File: tb/sim_vic_entry.sv
module sim_vic_entry;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqHandler = '0;
  logic [2:0]  reqBank = '0;
  logic [5:0]  reqLevel = '0;
  logic        reqNmi = 1'b0;
  logic [31:0] curStatus = '0;
  logic [31:0] curPc = '0;
  logic statusWe, xsWe, bankStWe, bankRaWe;
  logic [31:0] newStatus, newPc, xsData, bankStData, bankRaData;
  logic [2:0] bankStSel, bankRaSel;
  logic [4:0] bankStIdx, bankRaIdx;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vic_entry u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqHandler(reqHandler), .reqBank(reqBank), .reqLevel(reqLevel),
    .reqNmi(reqNmi), .curStatus(curStatus), .curPc(curPc),
    .statusWe(statusWe), .newStatus(newStatus), .newPc(newPc),
    .xsWe(xsWe), .xsData(xsData),
    .bankStWe(bankStWe), .bankStSel(bankStSel), .bankStIdx(bankStIdx),
    .bankStData(bankStData),
    .bankRaWe(bankRaWe), .bankRaSel(bankRaSel), .bankRaIdx(bankRaIdx),
    .bankRaData(bankRaData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(logic [31:0] old, logic [2:0] bank,
                                            logic [5:0] lvl, logic nmi);
    logic [31:0] s = old;
    s[15:10] = {3'b0, bank};
    s[9:4]   = lvl;
    s[22]    = nmi;
    s[23]    = 1'b0;
    s[1]     = 1'b0;
    s[3]     = 1'b1;
    if (!old[2]) s[21:16] = old[15:10];
    return s;
  endfunction

  task automatic drive(input logic [2:0] bank, input logic [5:0] lvl, input logic nmi,
                       input logic [31:0] hnd, input logic [31:0] st, input logic [31:0] pc);
    reqValid = 1'b1; reqBank = bank; reqLevel = lvl; reqNmi = nmi;
    reqHandler = hnd; curStatus = st; curPc = pc;
  endtask

  // Checks outputs one edge after acceptance of the given request.
  task automatic judge(input logic [2:0] bank, input logic [5:0] lvl, input logic nmi,
                       input logic [31:0] hnd, input logic [31:0] st, input logic [31:0] pc);
    logic free = !st[2];
    logic switched = {3'b0, bank} != st[15:10];
    chk("R2 statusWe", {31'b0, statusWe}, 32'd1);
    chk("R2/R4 newStatus", newStatus, expStatus(st, bank, lvl, nmi));
    chk("R3 newPc", newPc, hnd);
    chk("R5 xsWe", {31'b0, xsWe}, {31'b0, free && bank == 0});
    chk("R6 bankStWe", {31'b0, bankStWe}, {31'b0, free && bank != 0});
    chk("R7 bankRaWe", {31'b0, bankRaWe}, {31'b0, free});
    if (free && bank == 0) chk("R5 xsData", xsData, st);
    if (free && bank != 0) begin
      chk("R6 bankStData", bankStData, switched ? (st | 32'h8000_0000) : st);
      chk("R6 bankStSel", {29'b0, bankStSel}, {29'b0, bank});
      chk("R6 bankStIdx", {27'b0, bankStIdx}, 32'd30);
    end
    if (free) begin
      chk("R7 bankRaData", bankRaData, pc);
      chk("R7 bankRaSel", {29'b0, bankRaSel}, {29'b0, bank});
      chk("R7 bankRaIdx", {27'b0, bankRaIdx}, 32'd29);
    end
  endtask

  task automatic single(input logic [2:0] bank, input logic [5:0] lvl, input logic nmi,
                        input logic [31:0] hnd, input logic [31:0] st, input logic [31:0] pc);
    @(negedge clk); drive(bank, lvl, nmi, hnd, st, pc);
    @(negedge clk); reqValid = 1'b0;
    judge(bank, lvl, nmi, hnd, st, pc);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready in reset", {31'b0, reqReady}, 32'd0);
    chk("R1 strobes in reset", {28'b0, statusWe, xsWe, bankStWe, bankRaWe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, reqReady}, 32'd1);
    chk("R1 strobes idle", {28'b0, statusWe, xsWe, bankStWe, bankRaWe}, 32'd0);
  endtask

  task automatic t_bankZero();
    // old CurBank 2, User and BankIrqEn set, ExcBusy clear
    single(3'd0, 6'd17, 1'b0, 32'h0000_4000, 32'h0080_0803, 32'h0000_1234);
  endtask

  task automatic t_bankSwitch();
    single(3'd5, 6'd3, 1'b1, 32'h0001_0100, 32'h0000_0401, 32'h0000_9000);
  endtask

  task automatic t_bankSame();
    single(3'd3, 6'd9, 1'b0, 32'h0002_0000, 32'h0000_0C12, 32'h0000_5554);
  endtask

  task automatic t_excBusy();
    // ExcBusy set, PrevBank 4 must survive, no saves
    single(3'd6, 6'd1, 1'b0, 32'h0003_0000, 32'h0004_0406, 32'h0000_7770);
    chk("R8 no xs", {31'b0, xsWe}, 32'd0);
    chk("R8 no bank", {30'b0, bankStWe, bankRaWe}, 32'd0);
  endtask

  task automatic t_backToBack();
    @(negedge clk); drive(3'd1, 6'd2, 1'b0, 32'h0000_A000, 32'h0000_0000, 32'h0000_0100);
    @(negedge clk);
    judge(3'd1, 6'd2, 1'b0, 32'h0000_A000, 32'h0000_0000, 32'h0000_0100);
    drive(3'd0, 6'd7, 1'b1, 32'h0000_B000, 32'h0000_0402, 32'h0000_0200);
    @(negedge clk); reqValid = 1'b0;
    judge(3'd0, 6'd7, 1'b1, 32'h0000_B000, 32'h0000_0402, 32'h0000_0200);
    reqHandler = 32'hDEAD_0000; reqBank = 3'd4;
    @(negedge clk);
    chk("R9 idle strobes", {28'b0, statusWe, xsWe, bankStWe, bankRaWe}, 32'd0);
    chk("R9 pc held", newPc, 32'h0000_B000);
  endtask

  initial begin
    t_reset();
    t_bankZero();
    t_bankSwitch();
    t_bankSame();
    t_excBusy();
    t_backToBack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule